// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder with Control Word

This block adds or subtracts two 32-bit binary floating-point values. A control word sets how each operation behaves. It selects the rounding direction. It says whether tiny operands are read as zero and whether tiny results are forced to zero. It also holds one mask bit per exception class. The block handles signed zeros, subnormals, infinities and both kinds of NaN. Every operation posts its exception conditions into sticky flag bits. If any of those conditions is unmasked, the block also raises a trap request.

The arithmetic is one combinational path: unpack, align, add, normalise, round, then special-case override. Its outputs are registered. A `start` pulse launches an operation, and the result, the flags and the trap request appear on the next cycle together with a one-cycle `valid` strobe. Software-side logic clears the sticky flags with `flag_clr` or loads them with `flag_wr`.

Top module: `fpadd_top`

## Requirements
- R1: Finite operands are added (`sub`=0) or subtracted (`sub`=1) with a correctly rounded result in the 1/8/23 format (bias 127, hidden 1 for normal values). Example: 1.5 + 2.25 gives 0x40700000.
- R2: `rmode` encodes 00 = nearest, ties to even; 01 = toward minus infinity; 10 = toward plus infinity; 11 = toward zero. Each result is rounded in the selected direction.
- R3: Any NaN operand gives 0x7FC00000. A signalling NaN (exponent all ones, fraction MSB 0, fraction nonzero) raises invalid, and a quiet NaN raises nothing. Infinities of opposite effective sign raise invalid and give 0x7FC00000. Any other infinity passes through with its own sign. The divide-by-zero flag (bit 1) is never raised by an operation.
- R4: An exact zero from operands of opposite effective sign is +0, except under rounding toward minus infinity, where it is -0. Two zeros of the same sign give that sign.
- R5: With `daz`=1, subnormal operands are read as zero of the same sign. With `daz`=0, they take part at full precision.
- R6: With `ftz`=1, a nonzero result that would be subnormal is replaced by a zero of the same sign, and underflow and inexact are both raised. Normal results are untouched.
- R7: Overflow raises overflow and inexact. The result is infinity, except that the largest finite value (exponent 0xFE, fraction all ones) is returned when rounding is toward zero or rounds away from that infinity's sign.
- R8: A rounded result that differs from the exact sum raises inexact (flag bit 4).
- R9: The flag bits are bit0 invalid, bit1 divide-by-zero, bit2 overflow, bit3 underflow and bit4 inexact. They are sticky: each operation ORs its new flags into them. `flag_clr` zeroes them, and `flag_wr` loads `flag_wdata`, with clear taking priority over write and write over accumulation.
- R10: `trap` is high with `valid` when the operation raised any flag whose `mask` bit (same bit positions as R9) is 0.
- R11: `result`, the flag update and `trap` appear one cycle after `start`, and `valid` is high for exactly that one cycle.
- R12: After reset, `result`, `valid`, `flags` and `trap` are all zero.
- R13: Subnormal operands without DAZ add exactly, including a sum that carries into the smallest normal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub | input | 1 | 1 = subtract `op_b` from `op_a` |
| rmode | input | 2 | Rounding direction (encoding in R2) |
| ftz | input | 1 | Force subnormal results to zero |
| daz | input | 1 | Read subnormal operands as zero |
| mask | input | 5 | Exception masks, 1 = masked |
| flag_clr | input | 1 | Clear the sticky flags |
| flag_wr | input | 1 | Load the sticky flags from `flag_wdata` |
| flag_wdata | input | 5 | Value for a flag load |
| result | output | 32 | Registered result |
| valid | output | 1 | One-cycle strobe marking a new result |
| flags | output | 5 | Sticky exception flags |
| trap | output | 1 | Trap request for an unmasked exception |

## Verification
The trap property compares `trap` against the mask sampled at the launch cycle, so it assumes `mask` is held steady from `start` until `valid`. The bench changes masks only between operations. The flushing property reads `ftz` one cycle back in the same way, and the stimulus holds all control inputs stable across each launch. The sticky-flag properties assume `flag_clr` and `flag_wr` are driven only as deliberate single-cycle pulses. The bench never overlaps them with `start`, so each vector's flags can be checked on their own after a preceding clear.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int MANT_W = FRAC_W + 1;
    localparam int GRD_W  = 3;
    localparam int EXT_W  = MANT_W + GRD_W;
    localparam int LZ_W   = $clog2(EXT_W + 1);
    localparam int NFLAG  = 5;

    localparam int FL_INV = 0;
    localparam int FL_DZ  = 1;
    localparam int FL_OVF = 2;
    localparam int FL_UNF = 3;
    localparam int FL_INX = 4;

    localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
        logic              is_inf;
        logic              is_nan;
        logic              is_snan;
    } opnd_t;
endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
    import fpadd_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              negate,
    input  logic              daz,
    output opnd_t             op
);
    logic [EXP_W-1:0]  efield;
    logic [FRAC_W-1:0] ffield;
    logic              e_zero;
    logic              e_ones;

    always_comb begin
        efield = word[WORD_W-2 -: EXP_W];
        ffield = word[FRAC_W-1:0];
        e_zero = (efield == '0);
        e_ones = (efield == '1);

        op.sign    = word[WORD_W-1] ^ negate;
        op.is_inf  = e_ones && (ffield == '0);
        op.is_nan  = e_ones && (ffield != '0);
        op.is_snan = e_ones && (ffield != '0) && !ffield[FRAC_W-1];
        // subnormals sit at effective exponent 1 with a hidden 0
        op.exp     = e_zero ? EXP_W'(1) : efield;
        if (e_zero && daz)
            op.mant = '0;
        else
            op.mant = {!e_zero, ffield};
    end
endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
    import fpadd_pkg::*;
(
    input  opnd_t             x,
    input  opnd_t             y,
    input  rmode_e            rm,
    input  logic              ftz,
    output logic [WORD_W-1:0] res,
    output logic [NFLAG-1:0]  flg
);
    localparam int EW = EXP_W + 2;

    function automatic logic [LZ_W-1:0] lead_zeros(input logic [EXT_W-1:0] v);
        logic [LZ_W-1:0] n;
        logic            hit;
        n   = '0;
        hit = 1'b0;
        for (int i = EXT_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      n   = n + 1'b1;
            end
        end
        return n;
    endfunction

    logic                 swap, eff_sub, b_sign;
    logic [EXP_W-1:0]     b_exp, s_exp, diff, shamt;
    logic [MANT_W-1:0]    b_mant, s_mant;
    logic [2*EXT_W-1:0]   wide;
    logic [EXT_W-1:0]     al;
    logic [EXT_W:0]       sum;
    logic [EW-1:0]        e0, e1, e2, lim, lzx, sh;
    logic [EXT_W-1:0]     nrm;
    logic [MANT_W-1:0]    keep;
    logic                 rb, sb, inexact, up, max_mag;
    logic [MANT_W:0]      rnd;
    logic [FRAC_W-1:0]    frac;

    always_comb begin
        // order by magnitude
        swap    = {y.exp, y.mant} > {x.exp, x.mant};
        b_sign  = swap ? y.sign : x.sign;
        b_exp   = swap ? y.exp  : x.exp;
        b_mant  = swap ? y.mant : x.mant;
        s_exp   = swap ? x.exp  : y.exp;
        s_mant  = swap ? x.mant : y.mant;
        eff_sub = x.sign ^ y.sign;

        // align smaller operand; shifted-out bits fold into the LSB
        diff  = b_exp - s_exp;
        shamt = (diff > EXP_W'(EXT_W)) ? EXP_W'(EXT_W) : diff;
        wide  = {s_mant, {GRD_W{1'b0}}, {EXT_W{1'b0}}} >> shamt;
        al    = {wide[2*EXT_W-1:EXT_W+1], wide[EXT_W] | (|wide[EXT_W-1:0])};

        sum = eff_sub ? ({1'b0, b_mant, {GRD_W{1'b0}}} - {1'b0, al})
                      : ({1'b0, b_mant, {GRD_W{1'b0}}} + {1'b0, al});

        // normalise, never below effective exponent 1
        e0  = EW'(b_exp);
        lim = e0 - 1'b1;
        lzx = EW'(lead_zeros(sum[EXT_W-1:0]));
        sh  = (lzx < lim) ? lzx : lim;
        if (sum[EXT_W]) begin
            nrm = {sum[EXT_W:2], sum[1] | sum[0]};
            e1  = e0 + 1'b1;
        end else begin
            nrm = sum[EXT_W-1:0] << sh;
            e1  = e0 - sh;
        end

        // round
        keep    = nrm[EXT_W-1:GRD_W];
        rb      = nrm[GRD_W-1];
        sb      = |nrm[GRD_W-2:0];
        inexact = rb | sb;
        unique case (rm)
            RM_NEAR: up = rb & (sb | keep[0]);
            RM_UP:   up = inexact & !b_sign;
            RM_DOWN: up = inexact & b_sign;
            RM_ZERO: up = 1'b0;
        endcase
        rnd = {1'b0, keep} + (MANT_W+1)'(up);
        if (rnd[MANT_W]) begin
            e2   = e1 + 1'b1;
            frac = rnd[FRAC_W:1];
        end else if (rnd[FRAC_W]) begin
            e2   = e1;
            frac = rnd[FRAC_W-1:0];
        end else begin
            e2   = '0;
            frac = rnd[FRAC_W-1:0];
        end

        max_mag = (rm == RM_ZERO) || (rm == RM_UP && b_sign) || (rm == RM_DOWN && !b_sign);
        flg     = '0;
        flg[FL_INX] = inexact;
        res     = {b_sign, e2[EXP_W-1:0], frac};

        if (e2 >= EW'({EXP_W{1'b1}})) begin
            flg[FL_OVF] = 1'b1;
            flg[FL_INX] = 1'b1;
            res = max_mag ? {b_sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}}
                          : {b_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (sum == '0) begin
            res = {eff_sub ? (rm == RM_DOWN) : b_sign, {(WORD_W-1){1'b0}}};
        end else if (e2 == '0) begin
            flg[FL_UNF] = inexact;
            if (ftz) begin
                res = {b_sign, {(WORD_W-1){1'b0}}};
                flg[FL_UNF] = 1'b1;
                flg[FL_INX] = 1'b1;
            end
        end

        // special operands override the datapath
        if (x.is_nan || y.is_nan) begin
            res = QNAN_WORD;
            flg = '0;
            flg[FL_INV] = x.is_snan || y.is_snan;
        end else if (x.is_inf || y.is_inf) begin
            flg = '0;
            if (x.is_inf && y.is_inf && eff_sub) begin
                res = QNAN_WORD;
                flg[FL_INV] = 1'b1;
            end else begin
                res = {x.is_inf ? x.sign : y.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end
        end
    end

    always_comb begin
        assert_ovf_implies_inexact_R7: assert (!flg[FL_OVF] || flg[FL_INX]);
        assert_no_divzero_R3: assert (!flg[FL_DZ]);
    end
endmodule

// File: rtl/fpadd_top.sv
module fpadd_top
    import fpadd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub,
    input  logic [1:0]        rmode,
    input  logic              ftz,
    input  logic              daz,
    input  logic [NFLAG-1:0]  mask,
    input  logic              flag_clr,
    input  logic              flag_wr,
    input  logic [NFLAG-1:0]  flag_wdata,
    output logic [WORD_W-1:0] result,
    output logic              valid,
    output logic [NFLAG-1:0]  flags,
    output logic              trap
);
    opnd_t             ua, ub;
    logic [WORD_W-1:0] sum_word;
    logic [NFLAG-1:0]  new_flg;

    fpadd_unpack u_ua (.word(op_a), .negate(1'b0), .daz(daz), .op(ua));
    fpadd_unpack u_ub (.word(op_b), .negate(sub),  .daz(daz), .op(ub));

    fpadd_core u_core (
        .x   (ua),
        .y   (ub),
        .rm  (rmode_e'(rmode)),
        .ftz (ftz),
        .res (sum_word),
        .flg (new_flg)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            valid  <= 1'b0;
            trap   <= 1'b0;
            flags  <= '0;
        end else begin
            valid <= start;
            trap  <= start && |(new_flg & ~mask);
            if (start) result <= sum_word;
            if (flag_clr)     flags <= '0;
            else if (flag_wr) flags <= flag_wdata;
            else if (start)   flags <= flags | new_flg;
        end
    end

    assert_valid_after_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    assert_valid_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
    assert_trap_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> valid);
    assert_trap_unmasked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trap && !$past(flag_clr) && !$past(flag_wr)) |-> |(flags & ~$past(mask)));
    assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr && !flag_wr) |=> ((flags & $past(flags)) == $past(flags)));
    assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr |=> (flags == '0));
    assert_ftz_no_subnormal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(ftz)) |-> !(result[WORD_W-2 -: EXP_W] == '0 && result[FRAC_W-1:0] != '0));
endmodule

// File: tb/tb_fpadd_top.sv
module tb_fpadd_top;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG = 20000;
    localparam logic [4:0] F_I = 5'h01, F_O = 5'h04, F_U = 5'h08, F_P = 5'h10;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        sb;
        logic [1:0]  rm;
        logic        fz;
        logic        dz;
        logic [31:0] res;
        logic [4:0]  flg;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VECS [NV] = '{
        '{32'h3F800000, 32'h3F800000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h40000000, 5'h00, 8'd1},  // R1
        '{32'h3FC00000, 32'h40100000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h40700000, 5'h00, 8'd1},  // R1
        '{32'h3F800001, 32'h3F800000, 1'b1, 2'd0, 1'b0, 1'b0, 32'h34000000, 5'h00, 8'd1},  // R1
        '{32'h3F800000, 32'h3F800000, 1'b1, 2'd0, 1'b0, 1'b0, 32'h00000000, 5'h00, 8'd4},  // R4
        '{32'h3F800000, 32'h3F800000, 1'b1, 2'd1, 1'b0, 1'b0, 32'h80000000, 5'h00, 8'd4},  // R4
        '{32'h80000000, 32'h80000000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h80000000, 5'h00, 8'd4},  // R4
        '{32'h3F800000, 32'h33800000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h3F800000, F_P,   8'd2},  // R2
        '{32'h3F800000, 32'h33800000, 1'b0, 2'd2, 1'b0, 1'b0, 32'h3F800001, F_P,   8'd2},  // R2
        '{32'hBF800000, 32'hB3800000, 1'b0, 2'd1, 1'b0, 1'b0, 32'hBF800001, F_P,   8'd2},  // R2
        '{32'hBF800000, 32'hB3800000, 1'b0, 2'd3, 1'b0, 1'b0, 32'hBF800000, F_P,   8'd2},  // R2
        '{32'h4B800000, 32'h3F800000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h4B800000, F_P,   8'd8},  // R8
        '{32'h4B800000, 32'h3F800000, 1'b0, 2'd2, 1'b0, 1'b0, 32'h4B800001, F_P,   8'd8},  // R8
        '{32'h7F800000, 32'hFF800000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h7FC00000, F_I,   8'd3},  // R3
        '{32'h7F800000, 32'h7F800000, 1'b1, 2'd0, 1'b0, 1'b0, 32'h7FC00000, F_I,   8'd3},  // R3
        '{32'h7F800000, 32'h3F800000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h7F800000, 5'h00, 8'd3},  // R3
        '{32'h7F800001, 32'h3F800000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h7FC00000, F_I,   8'd3},  // R3
        '{32'h7FC00001, 32'h3F800000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h7FC00000, 5'h00, 8'd3},  // R3
        '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd0, 1'b0, 1'b0, 32'h7F800000, 5'h14, 8'd7},  // R7
        '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd3, 1'b0, 1'b0, 32'h7F7FFFFF, 5'h14, 8'd7},  // R7
        '{32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 2'd1, 1'b0, 1'b0, 32'h7F7FFFFF, 5'h14, 8'd7},  // R7
        '{32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 2'd1, 1'b0, 1'b0, 32'hFF800000, 5'h14, 8'd7},  // R7
        '{32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 2'd2, 1'b0, 1'b0, 32'hFF7FFFFF, 5'h14, 8'd7},  // R7
        '{32'h00000001, 32'h00000001, 1'b0, 2'd0, 1'b0, 1'b0, 32'h00000002, 5'h00, 8'd13}, // R13
        '{32'h00400000, 32'h00400000, 1'b0, 2'd0, 1'b0, 1'b0, 32'h00800000, 5'h00, 8'd13}, // R13
        '{32'h3F800000, 32'h00000001, 1'b0, 2'd0, 1'b0, 1'b0, 32'h3F800000, F_P,   8'd5},  // R5
        '{32'h3F800000, 32'h00000001, 1'b0, 2'd0, 1'b0, 1'b1, 32'h3F800000, 5'h00, 8'd5},  // R5
        '{32'h00000005, 32'h00000003, 1'b1, 2'd0, 1'b0, 1'b1, 32'h00000000, 5'h00, 8'd5},  // R5
        '{32'h00000003, 32'h00000001, 1'b1, 2'd0, 1'b1, 1'b0, 32'h00000000, 5'h18, 8'd6},  // R6
        '{32'h00000003, 32'h00000001, 1'b1, 2'd0, 1'b0, 1'b0, 32'h00000002, 5'h00, 8'd6},  // R6
        '{32'h80000003, 32'h00000001, 1'b0, 2'd0, 1'b1, 1'b0, 32'h80000000, 5'h18, 8'd6},  // R6
        '{32'h00400000, 32'h00400000, 1'b0, 2'd0, 1'b1, 1'b0, 32'h00800000, 5'h00, 8'd6}   // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        sub = 1'b0;
    logic [1:0]  rmode = '0;
    logic        ftz = 1'b0, daz = 1'b0;
    logic [4:0]  mask = 5'h1F;
    logic        flag_clr = 1'b0, flag_wr = 1'b0;
    logic [4:0]  flag_wdata = '0;
    logic [31:0] result;
    logic        valid;
    logic [4:0]  flags;
    logic        trap;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    fpadd_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .sub(sub), .rmode(rmode), .ftz(ftz), .daz(daz), .mask(mask),
        .flag_clr(flag_clr), .flag_wr(flag_wr), .flag_wdata(flag_wdata),
        .result(result), .valid(valid), .flags(flags), .trap(trap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic clear_flags();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic run_op(input vec_t v);
        @(negedge clk);
        op_a = v.a; op_b = v.b; sub = v.sb; rmode = v.rm; ftz = v.fz; daz = v.dz;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 reset result", result, 32'h0);
        check("R12 reset valid", {31'b0, valid}, 32'h0);
        check("R12 reset flags", {27'b0, flags}, 32'h0);
        check("R12 reset trap", {31'b0, trap}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            clear_flags();
            run_op(VECS[i]);
            check($sformatf("R%0d vec %0d result", VECS[i].req, i), result, VECS[i].res);
            check($sformatf("R%0d vec %0d flags", VECS[i].req, i), {27'b0, flags}, {27'b0, VECS[i].flg});
            check($sformatf("R3 vec %0d divide-by-zero flag", i), {31'b0, flags[1]}, 32'h0);
        end

        // R11: valid lasts exactly one cycle
        clear_flags();
        run_op(VECS[0]);
        check("R11 valid after start", {31'b0, valid}, 32'h1);
        @(negedge clk);
        check("R11 valid drops", {31'b0, valid}, 32'h0);
        check("R11 result held", result, 32'h40000000);

        // R9: accumulation, load, clear
        clear_flags();
        run_op(VECS[6]);
        run_op(VECS[12]);
        check("R9 flags accumulate", {27'b0, flags}, {27'b0, F_P | F_I});
        @(negedge clk) begin flag_wr = 1'b1; flag_wdata = 5'h0A; end
        @(negedge clk) flag_wr = 1'b0;
        check("R9 flag load", {27'b0, flags}, 32'h0A);
        run_op(VECS[0]);
        check("R9 exact op keeps flags", {27'b0, flags}, 32'h0A);
        clear_flags();
        check("R9 flag clear", {27'b0, flags}, 32'h0);

        // R10: traps follow masks
        mask = 5'h0F;
        run_op(VECS[6]);
        check("R10 unmasked inexact traps", {31'b0, trap}, 32'h1);
        mask = 5'h1F;
        run_op(VECS[6]);
        check("R10 masked inexact no trap", {31'b0, trap}, 32'h0);
        mask = 5'h1B;
        run_op(VECS[6]);
        check("R10 other class unmasked no trap", {31'b0, trap}, 32'h0);
        run_op(VECS[17]);
        check("R10 unmasked overflow traps", {31'b0, trap}, 32'h1);
        @(negedge clk);
        check("R10 trap drops with valid", {31'b0, trap}, 32'h0);
        mask = 5'h1F;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule